// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a virtual address into a physical address by walking a radix tree of page tables held in memory. Each table fills one 4096-byte page and holds 512 entries of 8 bytes. A request carries the virtual address, the kind of access (load, store or instruction fetch) and a user-mode flag. The walk starts at the table whose page number comes from a root register input. The walker reads one entry per level and uses 9 bits of the virtual page number as the index at each level, starting from the most significant group.

Every entry is decoded from its low flag bits. The decode either sends the walk down to the next table, ends it at a leaf, or stops it with a page fault. A leaf found at the lowest level is checked against the access kind and the privilege of the request. The walker then reports either the leaf's page number joined to the untouched 12-bit offset, or a fault. Only one memory read is in flight at any time. A new request is taken only while the walker is idle. The number of levels and all field widths are parameters. A two-level, 30-bit configuration is built from the same source.

Top module: `vmap_walker`

## Requirements
- R1: The page offset is vaddr[11:0] and the index for level L is vaddr[12+9L +: 9], so the highest level uses the most significant bits. The entry for a level is read at byte address table_page × 4096 + index × 8.
- R2: The first read uses root_ppn at the top level. An entry with V=1 and R=W=X=0 is a pointer: its bits [53:10] give the page of the table for the next lower level. Flag positions are V=bit 0, R=bit 1, W=bit 2, X=bit 3, U=bit 4. Bits 5 to 9 do not affect the walk.
- R3: A permitted leaf at level 0 ends the walk with done_fault=0 and done_paddr = {entry bits [53:10], vaddr[11:0]}.
- R4: An entry with V=0, or with W=1 and R=0, ends the walk at once with done_fault=1. No further memory read is issued.
- R5: A leaf (any of R, W, X set) above level 0 faults. A pointer read at level 0 also faults.
- R6: req_kind 0 (load) needs R, 1 (store) needs W and 2 (fetch) needs X. Kind 3 always faults. With req_user=1 the leaf must also have U=1.
- R7: mem_req_valid is a one-cycle pulse. No new read is issued before the response to the previous one has arrived on mem_rsp_valid.
- R8: req_ready is high only while idle. A request presented while a walk is running is ignored: it does not change the result and does not start a walk.
- R9: The first read is issued in the cycle after a request is accepted. done_valid is a one-cycle pulse, and req_ready is high again in the following cycle.
- R10: After reset, req_ready=1, mem_req_valid=0 and done_valid=0.
- R11: With LEVELS=2 and a 30-bit address, the following setup must give paddr 0xCAFE008 for vaddr 0x3FFFF008: a top-level entry at index 511 pointing to page 0x8, and a leaf with page 0xCAFE at index 511 of the table at 0x8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_ppn | input | PPN_BITS | Page number of the top-level table |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request taken |
| req_vaddr | input | VA_BITS | Virtual address to translate |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 reserved |
| req_user | input | 1 | Request made in user mode |
| mem_req_valid | output | 1 | Entry read strobe |
| mem_req_addr | output | PA_BITS | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | PTE_BITS | Entry returned by memory |
| done_valid | output | 1 | Walk finished (one cycle) |
| done_fault | output | 1 | Page fault for the finished walk |
| done_paddr | output | PA_BITS | Physical address when no fault |

## Verification
If the level counter or the held table page is wrong, the next entry read goes to an address the bench memory has not filled. That read returns an invalid entry, and the walk faults one response later, so the error shows in the same walk. A wrong state sequence shows at once in the read count per walk, in back-to-back read strobes, or in a done pulse that lasts more than one cycle. The sweep covers every combination of the five low flag bits in a level-0 leaf with every access kind and privilege, at varying indices and offsets, so a decode or permission error appears as a wrong fault bit or a wrong address.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } access_e;

   // last member is bit 0
   typedef struct packed {
      logic d;
      logic a;
      logic g;
      logic u;
      logic x;
      logic w;
      logic r;
      logic v;
   } pte_flags_t;

   typedef enum logic [1:0] {
      WS_IDLE,
      WS_READ,
      WS_WAIT,
      WS_DONE
   } walk_state_e;
endpackage

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode
   import ptw_pkg::*;
#(
   parameter int PTE_BITS = 64,
   parameter int PPN_BITS = 44
) (
   input  logic [PTE_BITS-1:0] pte,
   output pte_flags_t          flags,
   output logic [PPN_BITS-1:0] ppn,
   output logic                is_bad,
   output logic                is_ptr,
   output logic                is_leaf
);
   localparam int PPN_LSB = 10;

   logic any_perm;
   logic unused_bits;

   assign flags    = pte_flags_t'(pte[7:0]);
   assign ppn      = pte[PPN_LSB +: PPN_BITS];
   assign any_perm = flags.r | flags.w | flags.x;
   assign is_bad   = !flags.v || (flags.w && !flags.r);
   assign is_ptr   = !is_bad && !any_perm;
   assign is_leaf  = !is_bad && any_perm;

   generate
      if (PTE_BITS > PPN_LSB + PPN_BITS) begin : g_hi
         assign unused_bits = ^{pte[9:8], pte[PTE_BITS-1:PPN_LSB+PPN_BITS]};
      end else begin : g_nohi
         assign unused_bits = ^pte[9:8];
      end
   endgenerate
endmodule

// File: rtl/ptw_leaf_check.sv
module ptw_leaf_check
   import ptw_pkg::*;
#(
   parameter bit USER_CHECK = 1'b1
) (
   input  pte_flags_t flags,
   input  access_e    kind,
   input  logic       user,
   output logic       deny
);
   logic need_ok;
   logic priv_ok;
   logic unused_flags;

   assign unused_flags = ^{flags.g, flags.a, flags.d, flags.v};

   always_comb begin
      unique case (kind)
         ACC_LOAD:  need_ok = flags.r;
         ACC_STORE: need_ok = flags.w;
         ACC_FETCH: need_ok = flags.x;
         default:   need_ok = 1'b0;
      endcase
   end

   generate
      if (USER_CHECK) begin : g_priv
         assign priv_ok = !user || flags.u;
      end else begin : g_nopriv
         assign priv_ok = 1'b1 | (user & flags.u);
      end
   endgenerate

   assign deny = !(need_ok && priv_ok);
endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
   parameter int VA_BITS     = 39,
   parameter int LEVELS      = 3,
   parameter int IDX_BITS    = 9,
   parameter int OFF_BITS    = 12,
   parameter int PPN_BITS    = 44,
   parameter int ENTRY_SHIFT = 3,
   parameter int LVL_W       = 2
) (
   input  logic [PPN_BITS-1:0]          table_ppn,
   input  logic [VA_BITS-1:0]           vaddr,
   input  logic [LVL_W-1:0]             level,
   output logic [PPN_BITS+OFF_BITS-1:0] addr
);
   logic [IDX_BITS-1:0] idx_by_lvl [LEVELS];
   logic                unused_off;

   generate
      for (genvar l = 0; l < LEVELS; l++) begin : g_idx
         assign idx_by_lvl[l] = vaddr[OFF_BITS + l*IDX_BITS +: IDX_BITS];
      end
   endgenerate

   assign unused_off = ^vaddr[OFF_BITS-1:0];
   assign addr = {table_ppn, idx_by_lvl[level], {ENTRY_SHIFT{1'b0}}};
endmodule

// File: rtl/vmap_walker.sv
module vmap_walker
   import ptw_pkg::*;
#(
   parameter int VA_BITS    = 39,
   parameter int LEVELS     = 3,
   parameter int IDX_BITS   = 9,
   parameter int OFF_BITS   = 12,
   parameter int PPN_BITS   = 44,
   parameter int PTE_BITS   = 64,
   parameter bit USER_CHECK = 1'b1,
   localparam int PA_BITS     = PPN_BITS + OFF_BITS,
   localparam int LVL_W       = $clog2(LEVELS),
   localparam int ENTRY_SHIFT = $clog2(PTE_BITS / 8)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [PPN_BITS-1:0] root_ppn,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [VA_BITS-1:0]  req_vaddr,
   input  logic [1:0]          req_kind,
   input  logic                req_user,
   output logic                mem_req_valid,
   output logic [PA_BITS-1:0]  mem_req_addr,
   input  logic                mem_rsp_valid,
   input  logic [PTE_BITS-1:0] mem_rsp_data,
   output logic                done_valid,
   output logic                done_fault,
   output logic [PA_BITS-1:0]  done_paddr
);
   // elaboration checks
   generate
      if (LEVELS < 2) begin : g_chk_lv
         $error("walker needs at least two levels");
      end
      if (VA_BITS != OFF_BITS + LEVELS * IDX_BITS) begin : g_chk_va
         $error("virtual width does not match offset plus indices");
      end
      if (IDX_BITS + ENTRY_SHIFT != OFF_BITS) begin : g_chk_pg
         $error("one table must fill exactly one page");
      end
      if (PTE_BITS < 10 + PPN_BITS) begin : g_chk_pte
         $error("entry too narrow for its page number");
      end
   endgenerate

   walk_state_e         state;
   logic [LVL_W-1:0]    level;
   logic [PPN_BITS-1:0] table_ppn;
   logic [VA_BITS-1:0]  va_q;
   access_e             kind_q;
   logic                user_q;
   logic                fault_q;
   logic [PA_BITS-1:0]  paddr_q;

   pte_flags_t          dec_flags;
   logic [PPN_BITS-1:0] dec_ppn;
   logic                dec_bad;
   logic                dec_ptr;
   logic                dec_leaf;
   logic                deny;
   logic                at_bottom;

   ptw_entry_decode #(.PTE_BITS(PTE_BITS), .PPN_BITS(PPN_BITS)) decode_i (
      .pte     (mem_rsp_data),
      .flags   (dec_flags),
      .ppn     (dec_ppn),
      .is_bad  (dec_bad),
      .is_ptr  (dec_ptr),
      .is_leaf (dec_leaf)
   );

   ptw_leaf_check #(.USER_CHECK(USER_CHECK)) perm_i (
      .flags (dec_flags),
      .kind  (kind_q),
      .user  (user_q),
      .deny  (deny)
   );

   ptw_entry_addr #(
      .VA_BITS     (VA_BITS),
      .LEVELS      (LEVELS),
      .IDX_BITS    (IDX_BITS),
      .OFF_BITS    (OFF_BITS),
      .PPN_BITS    (PPN_BITS),
      .ENTRY_SHIFT (ENTRY_SHIFT),
      .LVL_W       (LVL_W)
   ) addr_i (
      .table_ppn (table_ppn),
      .vaddr     (va_q),
      .level     (level),
      .addr      (mem_req_addr)
   );

   assign at_bottom = (level == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= WS_IDLE;
         level     <= '0;
         table_ppn <= '0;
         va_q      <= '0;
         kind_q    <= ACC_LOAD;
         user_q    <= 1'b0;
         fault_q   <= 1'b0;
         paddr_q   <= '0;
      end else begin
         unique case (state)
            WS_IDLE: if (req_valid) begin
               state     <= WS_READ;
               level     <= LVL_W'(LEVELS - 1);
               table_ppn <= root_ppn;
               va_q      <= req_vaddr;
               kind_q    <= access_e'(req_kind);
               user_q    <= req_user;
               fault_q   <= 1'b0;
               paddr_q   <= '0;
            end
            WS_READ: state <= WS_WAIT;
            WS_WAIT: if (mem_rsp_valid) begin
               if (dec_bad) begin
                  fault_q <= 1'b1;
                  state   <= WS_DONE;
               end else if (dec_ptr) begin
                  if (at_bottom) begin
                     fault_q <= 1'b1;
                     state   <= WS_DONE;
                  end else begin
                     level     <= level - 1'b1;
                     table_ppn <= dec_ppn;
                     state     <= WS_READ;
                  end
               end else begin
                  if (!at_bottom || deny || !dec_leaf) begin
                     fault_q <= 1'b1;
                  end else begin
                     paddr_q <= {dec_ppn, va_q[OFF_BITS-1:0]};
                  end
                  state <= WS_DONE;
               end
            end
            default: state <= WS_IDLE;
         endcase
      end
   end

   assign req_ready     = (state == WS_IDLE);
   assign mem_req_valid = (state == WS_READ);
   assign done_valid    = (state == WS_DONE);
   assign done_fault    = fault_q;
   assign done_paddr    = paddr_q;

   assert_one_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |=> !mem_req_valid);

   assert_no_read_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !req_ready);

   assert_accept_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> mem_req_valid);

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> (!done_valid && req_ready));

   assert_bad_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == WS_WAIT && mem_rsp_valid && !dec_flags.v) |=> (done_valid && done_fault));

   assert_upper_leaf_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == WS_WAIT && mem_rsp_valid && dec_leaf && !at_bottom) |=> (done_valid && done_fault));
endmodule

// File: tb/vmap_walker_tb_top.sv
`timescale 1ns/1ps
module vmap_walker_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   // three-level instance
   logic [43:0] root_a;
   logic        rq_v_a = 1'b0, rq_rdy_a, rq_user_a = 1'b0;
   logic [38:0] rq_va_a = '0;
   logic [1:0]  rq_kind_a = 2'd0;
   logic        mr_v_a, rs_v_a = 1'b0;
   logic [55:0] mr_addr_a;
   logic [63:0] rs_d_a = '0;
   logic        dn_v_a, dn_f_a;
   logic [55:0] dn_pa_a;

   // two-level instance
   logic [43:0] root_b;
   logic        rq_v_b = 1'b0, rq_rdy_b, rq_user_b = 1'b0;
   logic [29:0] rq_va_b = '0;
   logic [1:0]  rq_kind_b = 2'd0;
   logic        mr_v_b, rs_v_b = 1'b0;
   logic [55:0] mr_addr_b;
   logic [63:0] rs_d_b = '0;
   logic        dn_v_b, dn_f_b;
   logic [55:0] dn_pa_b;

   vmap_walker dut_i (
      .clk(clk), .rst_n(rst_n), .root_ppn(root_a),
      .req_valid(rq_v_a), .req_ready(rq_rdy_a), .req_vaddr(rq_va_a),
      .req_kind(rq_kind_a), .req_user(rq_user_a),
      .mem_req_valid(mr_v_a), .mem_req_addr(mr_addr_a),
      .mem_rsp_valid(rs_v_a), .mem_rsp_data(rs_d_a),
      .done_valid(dn_v_a), .done_fault(dn_f_a), .done_paddr(dn_pa_a)
   );

   vmap_walker #(.VA_BITS(30), .LEVELS(2)) dut2_i (
      .clk(clk), .rst_n(rst_n), .root_ppn(root_b),
      .req_valid(rq_v_b), .req_ready(rq_rdy_b), .req_vaddr(rq_va_b),
      .req_kind(rq_kind_b), .req_user(rq_user_b),
      .mem_req_valid(mr_v_b), .mem_req_addr(mr_addr_b),
      .mem_rsp_valid(rs_v_b), .mem_rsp_data(rs_d_b),
      .done_valid(dn_v_b), .done_fault(dn_f_b), .done_paddr(dn_pa_b)
   );

   logic [63:0] mem_a [longint];
   logic [63:0] mem_b [longint];
   int reads_a = 0;
   int reads_b = 0;
   int overlap = 0;

   always @(posedge clk) begin
      rs_v_a <= 1'b0;
      rs_v_b <= 1'b0;
      if (mr_v_a) begin
         if (rs_v_a) overlap <= overlap + 1;
         if (mr_v_a && rs_v_a === 1'b0 && reads_a < 0) overlap <= overlap + 1;
         reads_a <= reads_a + 1;
         rs_v_a  <= 1'b1;
         rs_d_a  <= mem_a.exists(longint'(mr_addr_a)) ? mem_a[longint'(mr_addr_a)] : 64'd0;
      end
      if (mr_v_b) begin
         reads_b <= reads_b + 1;
         rs_v_b  <= 1'b1;
         rs_d_b  <= mem_b.exists(longint'(mr_addr_b)) ? mem_b[longint'(mr_addr_b)] : 64'd0;
      end
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not end, actual %0d cycles expected < 150000", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] ptr_pte(input logic [43:0] ppn);
      return {10'd0, ppn, 10'h001};
   endfunction

   task automatic walk_a(input logic [38:0] va, input logic [1:0] kind, input logic user,
                         input bit poke,
                         output logic f, output logic [55:0] pa, output int nrd);
      int wait_n;
      @(negedge clk);
      rq_v_a = 1'b1; rq_va_a = va; rq_kind_a = kind; rq_user_a = user;
      reads_a = 0;
      @(negedge clk);
      rq_v_a = 1'b0;
      chk(mr_v_a === 1'b1, "R9", "read strobe after accept", 64'(mr_v_a), 64'd1);
      if (poke) begin
         rq_v_a = 1'b1; rq_va_a = ~va; rq_kind_a = 2'd3;
         repeat (3) @(negedge clk);
         rq_v_a = 1'b0; rq_va_a = va; rq_kind_a = kind;
      end
      wait_n = 0;
      while (dn_v_a !== 1'b1 && wait_n < 100) begin
         @(negedge clk);
         wait_n++;
      end
      chk(wait_n < 100, "R9", "walk finished", 64'(wait_n), 64'd0);
      f = dn_f_a; pa = dn_pa_a; nrd = reads_a;
      @(negedge clk);
      chk(dn_v_a === 1'b0 && rq_rdy_a === 1'b1, "R9", "done pulse then ready",
          {62'd0, dn_v_a, rq_rdy_a}, 64'd1);
   endtask

   task automatic walk_b(input logic [29:0] va, input logic [1:0] kind,
                         output logic f, output logic [55:0] pa, output int nrd);
      int wait_n;
      @(negedge clk);
      rq_v_b = 1'b1; rq_va_b = va; rq_kind_b = kind; rq_user_b = 1'b0;
      reads_b = 0;
      @(negedge clk);
      rq_v_b = 1'b0;
      wait_n = 0;
      while (dn_v_b !== 1'b1 && wait_n < 100) begin
         @(negedge clk);
         wait_n++;
      end
      chk(wait_n < 100, "R11", "two-level walk finished", 64'(wait_n), 64'd0);
      f = dn_f_b; pa = dn_pa_b; nrd = reads_b;
      @(negedge clk);
   endtask

   function automatic bit exp_fault(input logic [4:0] fl, input logic [1:0] kind, input logic user);
      logic v, r, w, x, u, need;
      {u, x, w, r, v} = fl;
      if (!v) return 1'b1;
      if (w && !r) return 1'b1;
      if (!(r || w || x)) return 1'b1;
      case (kind)
         2'd0: need = r;
         2'd1: need = w;
         2'd2: need = x;
         default: need = 1'b0;
      endcase
      if (!need) return 1'b1;
      if (user && !u) return 1'b1;
      return 1'b0;
   endfunction

   localparam logic [43:0] ROOT = 44'h100;
   localparam logic [43:0] MID  = 44'h200;
   localparam logic [43:0] BOT  = 44'h300;

   initial begin
      logic        f;
      logic [55:0] pa;
      int          nrd;
      int          iter;
      root_a = ROOT;
      root_b = 44'h5;

      // R10 reset state
      repeat (3) @(negedge clk);
      chk(rq_rdy_a === 1'b1, "R10", "ready in reset", 64'(rq_rdy_a), 64'd1);
      chk(mr_v_a === 1'b0 && dn_v_a === 1'b0, "R10", "no strobes in reset",
          {62'd0, mr_v_a, dn_v_a}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rq_rdy_a === 1'b1 && mr_v_a === 1'b0 && dn_v_a === 1'b0, "R10", "idle after reset",
          {61'd0, rq_rdy_a, mr_v_a, dn_v_a}, 64'h4);

      // R4 invalid root entry
      mem_a.delete();
      walk_a(39'h12_3456_7ABC, 2'd0, 1'b0, 1'b0, f, pa, nrd);
      chk(f === 1'b1, "R4", "invalid top entry faults", 64'(f), 64'd1);
      chk(nrd == 1, "R4", "one read on invalid top", 64'(nrd), 64'd1);

      // R4 W without R at top
      mem_a[longint'({ROOT, 9'd5, 3'b0})] = {10'd0, MID, 10'h005};
      walk_a({9'd5, 9'd1, 9'd2, 12'h0}, 2'd1, 1'b0, 1'b0, f, pa, nrd);
      chk(f === 1'b1 && nrd == 1, "R4", "write-only entry faults",
          {31'd0, f, 32'(nrd)}, {31'd0, 1'b1, 32'd1});

      // R5 leaf at top level and at middle level
      mem_a[longint'({ROOT, 9'd6, 3'b0})] = {10'd0, MID, 10'h00F};
      walk_a({9'd6, 9'd1, 9'd2, 12'h0}, 2'd0, 1'b0, 1'b0, f, pa, nrd);
      chk(f === 1'b1 && nrd == 1, "R5", "leaf at top level faults",
          {31'd0, f, 32'(nrd)}, {31'd0, 1'b1, 32'd1});
      mem_a[longint'({ROOT, 9'd7, 3'b0})] = ptr_pte(MID);
      mem_a[longint'({MID, 9'd9, 3'b0})]  = {10'd0, BOT, 10'h003};
      walk_a({9'd7, 9'd9, 9'd2, 12'h0}, 2'd0, 1'b0, 1'b0, f, pa, nrd);
      chk(f === 1'b1 && nrd == 2, "R5", "leaf at middle level faults",
          {31'd0, f, 32'(nrd)}, {31'd0, 1'b1, 32'd2});

      // R6 reserved kind with full permissions
      mem_a[longint'({ROOT, 9'd8, 3'b0})] = ptr_pte(MID);
      mem_a[longint'({MID, 9'd10, 3'b0})] = ptr_pte(BOT);
      mem_a[longint'({BOT, 9'd11, 3'b0})] = {10'd0, 44'hABC, 10'h01F};
      walk_a({9'd8, 9'd10, 9'd11, 12'h345}, 2'd3, 1'b0, 1'b0, f, pa, nrd);
      chk(f === 1'b1, "R6", "reserved kind faults", 64'(f), 64'd1);

      // R8 request during walk ignored
      walk_a({9'd8, 9'd10, 9'd11, 12'h345}, 2'd0, 1'b1, 1'b1, f, pa, nrd);
      chk(f === 1'b0 && pa === {44'hABC, 12'h345}, "R8", "busy request ignored",
          {7'd0, f, pa}, {8'd0, 44'hABC, 12'h345});
      chk(nrd == 3, "R8", "read count unchanged by busy request", 64'(nrd), 64'd3);
      repeat (3) @(negedge clk);
      chk(reads_a == 3 && rq_rdy_a === 1'b1, "R8", "no walk started by busy request",
          64'(reads_a), 64'd3);

      // R1 R2 R3 R5 R6 sweep over leaf flags, kinds, privilege
      for (int fl = 0; fl < 32; fl++) begin
         for (int kd = 0; kd < 3; kd++) begin
            for (int us = 0; us < 2; us++) begin
               logic [8:0]  i2, i1, i0;
               logic [11:0] off;
               logic [43:0] lppn;
               logic [38:0] va;
               bit          ef;
               iter = fl * 6 + kd * 2 + us;
               i2   = 9'((iter * 7) % 512);
               i1   = 9'((iter * 13 + 1) % 512);
               i0   = 9'((iter * 29 + 3) % 512);
               off  = 12'((iter * 37 + 5) % 4096);
               lppn = 44'h0123_4567_89A + 44'(iter);
               mem_a.delete();
               mem_a[longint'({ROOT, i2, 3'b0})] = ptr_pte(MID);
               mem_a[longint'({MID, i1, 3'b0})]  = ptr_pte(BOT);
               mem_a[longint'({BOT, i0, 3'b0})]  =
                  {10'd0, lppn, 2'(iter), 3'(iter * 3), 5'(fl)};
               va = {i2, i1, i0, off};
               walk_a(va, 2'(kd), 1'(us), 1'b0, f, pa, nrd);
               ef = exp_fault(5'(fl), 2'(kd), 1'(us));
               chk(f === ef, "R6", "leaf permission result", 64'(f), 64'(ef));
               chk(nrd == 3, "R2", "three reads for full walk", 64'(nrd), 64'd3);
               if (!ef) chk(pa === {lppn, off}, "R3", "translated address",
                            64'(pa), 64'({lppn, off}));
               if (fl[3:1] == 3'b000 && fl[0])
                  chk(f === 1'b1, "R5", "pointer at level 0 faults", 64'(f), 64'd1);
               if (!fl[0])
                  chk(f === 1'b1, "R1", "invalid leaf at computed address faults", 64'(f), 64'd1);
            end
         end
      end

      // R7 reads never overlap a response
      chk(overlap == 0, "R7", "read issued while response pending", 64'(overlap), 64'd0);

      // R11 two-level configuration
      mem_b[longint'({44'h5, 9'd511, 3'b0})] = ptr_pte(44'h8);
      mem_b[longint'(56'h8000 + 56'd511 * 56'd8)] = {10'd0, 44'hCAFE, 10'h003};
      walk_b(30'h3FFF_F008, 2'd0, f, pa, nrd);
      chk(f === 1'b0 && pa === 56'hCAFE008, "R11", "two-level translation",
          64'(pa), 64'h0CAFE008);
      chk(nrd == 2, "R11", "two reads in two-level walk", 64'(nrd), 64'd2);
      walk_b(30'h3FFF_F008, 2'd1, f, pa, nrd);
      chk(f === 1'b1, "R6", "store to read-only leaf faults", 64'(f), 64'd1);

      summary();
      $finish;
   end
endmodule